// File: doc/BRIEF.md
# Smart Display Host Register Interface

This block is the host-facing register and memory map of an eight-digit dot-matrix display controller. A host processor reaches it over an asynchronous parallel bus. The bus has an active-low chip select, separate active-low write and read strobes, an active-low flash-attribute select, five address lines and an 8-bit data path. The strobes are resynchronised into the system clock domain. Each chip-select period carries at most one write.

Behind the bus sit five stores:
- an eight-byte character store, holding either ASCII codes or user-glyph indices;
- an eight-bit flash-attribute vector;
- a four-bit user-glyph pointer;
- a 16-glyph by 7-row by 5-column user dot store;
- an 8-bit control byte that holds brightness, flash enable, blink, self-test start and clear.

Refresh logic elsewhere reads the character store, the flash vector and the dot store through dedicated read ports. The clear command and the external reset both blank the display over several display-clock ticks. While that runs, a busy output is high and host writes are discarded.

Top module: `disp_host_regs`

## Requirements
- R1: With `sel_flash_n` low, the access targets the flash vector whatever `bus_addr[4:3]` holds. With it high, `bus_addr[4:3]` selects a section: 00 is the glyph pointer, 01 is a glyph row, 10 is the control byte and 11 is the character store. `bus_addr[2:0]` picks the digit or the row.
- R2: A write is taken only while `bus_cs_n` and `bus_wr_n` are both low. At most one write is taken per low period of `bus_cs_n`. Strobing `bus_wr_n` with `bus_cs_n` high changes nothing.
- R3: `bus_oe` is high only while `bus_cs_n` and `bus_rd_n` are both low. `bus_dout` is 0 whenever `bus_oe` is low, and read bits with no storage behind them return 0.
- R4: Each of the eight character entries stores and returns all 8 bits. Entry 0 is the leftmost digit. On the refresh port, `rf_is_glyph` equals bit 7 of the entry. `rf_code` is bits 6:0 when bit 7 is 0, and the index in bits 3:0 (upper bits zero) when bit 7 is 1.
- R5: The glyph pointer keeps only data bits 3:0. A read returns them with bits 7:4 as zero.
- R6: A glyph-row write stores data bits 4:0 into row `bus_addr[2:0]` of the glyph named by the pointer, with bit 0 being the rightmost column; bits 7:5 are dropped. Row address 7 is not a row: writes to it are ignored and reads return 0. `rf_glyph_dots` returns the stored row for `rf_glyph`/`rf_row`.
- R7: In a flash write, data bit 0 sets (1) or removes (0) the attribute of the addressed digit. A flash read returns that bit in bit 0. `rf_flash` shows all eight attributes, with bit i for digit i.
- R8: A control write replaces every bit of the control byte. Bit 5 is read-only and always reflects `st_pass`; bits 2:0 are brightness, bit 3 flash enable, bit 4 blink, bit 6 self-test start and bit 7 clear.
- R9: Writing a 1 to control bit 7 raises `busy` on the write edge. For three `disp_tick` pulses the character store then holds 20h and the flash vector 0. After that, bit 7 returns to 0 and `busy` falls. Glyph rows, the glyph pointer and control bits 6:0 are unchanged.
- R10: While `rst_n` is low, and until three `disp_tick` pulses after it rises, `busy` is high. The character store reads 20h, and the flash vector and control byte read 0. Glyph rows and the glyph pointer keep their contents across reset.
- R11: Host writes that complete while `busy` is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_tick | input | 1 | One-cycle display clock enable |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| sel_flash_n | input | 1 | Flash vector select, active low |
| bus_addr | input | 5 | Section and location address |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| bus_oe | output | 1 | Read data output enable |
| st_pass | input | 1 | Self-test result shown in control bit 5 |
| busy | output | 1 | Clear or reset sequence running |
| ctrl_word | output | 8 | Control byte as read by the host |
| rf_digit | input | 3 | Refresh digit select |
| rf_char | output | 8 | Character entry for `rf_digit` |
| rf_is_glyph | output | 1 | Entry selects a user glyph |
| rf_code | output | 7 | ASCII code or glyph index of entry |
| rf_flash | output | 8 | Flash attribute per digit |
| rf_glyph | input | 4 | Refresh glyph select |
| rf_row | input | 3 | Refresh row select |
| rf_glyph_dots | output | 5 | Dot row for `rf_glyph`/`rf_row` |

## Verification
The assertions assume that the address, flash select and write data stay stable for the whole low period of chip select. They also assume that chip select returns high between cycles. The bench always sets these up before it lowers chip select and holds them past its rise. Strobes are held for at least four clocks so that the two-stage synchroniser sees them. The bench also attempts accesses only after the enforced busy window, except in the deliberate drop test during a clear.

// File: rtl/disp_host_pkg.sv
package disp_host_pkg;
  localparam int NDIG     = 8;
  localparam int NGLYPH   = 16;
  localparam int NROW     = 7;
  localparam int NCOL     = 5;
  localparam logic [7:0] BLANK_CODE = 8'h20;

  typedef enum logic [2:0] {
    SEC_FLASH,
    SEC_GPTR,
    SEC_GROW,
    SEC_CTRL,
    SEC_CHAR
  } sec_e;

  function automatic sec_e sec_decode(input logic fsel_n, input logic [1:0] hi);
    sec_e s;
    if (!fsel_n) s = SEC_FLASH;
    else begin
      case (hi)
        2'b00:   s = SEC_GPTR;
        2'b01:   s = SEC_GROW;
        2'b10:   s = SEC_CTRL;
        default: s = SEC_CHAR;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/disp_bus_front.sv
module disp_bus_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic wr_pulse
);
  logic [SYNC_STAGES-1:0] cs_sh_q, cs_sh_d;
  logic [SYNC_STAGES-1:0] wr_sh_q, wr_sh_d;
  logic done_q, done_d;
  logic cs_s, wr_s;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb begin
        cs_sh_d = cs_n;
        wr_sh_d = wr_n;
      end
    end else begin : g_many
      always_comb begin
        cs_sh_d = {cs_sh_q[SYNC_STAGES-2:0], cs_n};
        wr_sh_d = {wr_sh_q[SYNC_STAGES-2:0], wr_n};
      end
    end
  endgenerate

  assign cs_s = cs_sh_q[SYNC_STAGES-1];
  assign wr_s = wr_sh_q[SYNC_STAGES-1];
  assign wr_pulse = !cs_s && !wr_s && !done_q;

  always_comb begin
    done_d = done_q;
    if (cs_s) done_d = 1'b0;
    else if (wr_pulse) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sh_q <= '1;
      wr_sh_q <= '1;
      done_q  <= 1'b0;
    end else begin
      cs_sh_q <= cs_sh_d;
      wr_sh_q <= wr_sh_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/disp_init_seq.sv
module disp_init_seq #(
  parameter int TICKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic busy_q, busy_d;

  assign done = busy_q && tick && (cnt_q == LAST);
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (busy_q) begin
      if (done) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else if (tick) begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/disp_glyph_ram.sv
module disp_glyph_ram #(
  parameter int NG = 16,
  parameter int NR = 7,
  parameter int NC = 5
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [$clog2(NG)-1:0] widx,
  input  logic [2:0]            wrow,
  input  logic [NC-1:0]         wdata,
  input  logic [$clog2(NG)-1:0] ridx_a,
  input  logic [2:0]            rrow_a,
  output logic [NC-1:0]         rdata_a,
  input  logic [$clog2(NG)-1:0] ridx_b,
  input  logic [2:0]            rrow_b,
  output logic [NC-1:0]         rdata_b
);
  localparam int NENT = NG * NR;

  logic [NC-1:0] mem_q [NENT];

  generate
    for (genvar g = 0; g < NG; g++) begin : g_glyph
      for (genvar r = 0; r < NR; r++) begin : g_row
        logic hit;
        assign hit = we && (widx == g) && (wrow == 3'(r));
        always_ff @(posedge clk) begin
          if (hit) mem_q[g*NR + r] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    rdata_a = '0;
    rdata_b = '0;
    if (int'(rrow_a) < NR) rdata_a = mem_q[int'(ridx_a)*NR + int'(rrow_a)];
    if (int'(rrow_b) < NR) rdata_b = mem_q[int'(ridx_b)*NR + int'(rrow_b)];
  end
endmodule

// File: rtl/disp_host_regs.sv
module disp_host_regs
  import disp_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int INIT_TICKS  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       disp_tick,
  input  logic       bus_cs_n,
  input  logic       bus_wr_n,
  input  logic       bus_rd_n,
  input  logic       sel_flash_n,
  input  logic [4:0] bus_addr,
  input  logic [7:0] bus_din,
  output logic [7:0] bus_dout,
  output logic       bus_oe,
  input  logic       st_pass,
  output logic       busy,
  output logic [7:0] ctrl_word,
  input  logic [2:0] rf_digit,
  output logic [7:0] rf_char,
  output logic       rf_is_glyph,
  output logic [6:0] rf_code,
  output logic [7:0] rf_flash,
  input  logic [3:0] rf_glyph,
  input  logic [2:0] rf_row,
  output logic [4:0] rf_glyph_dots
);
  localparam int GW = $clog2(NGLYPH);
  localparam int DW = $clog2(NDIG);

  logic [7:0]    char_q [NDIG];
  logic [7:0]    char_d [NDIG];
  logic [NDIG-1:0] flash_q, flash_d;
  logic [7:0]    ctrl_q, ctrl_d;
  logic [GW-1:0] gptr_q, gptr_d;

  logic wr_pulse, wr_ok, clr_start, seq_done;
  logic glyph_we;
  logic [NCOL-1:0] host_dots;
  sec_e sec;
  logic [DW-1:0] loc;

  assign sec = sec_decode(sel_flash_n, bus_addr[4:3]);
  assign loc = bus_addr[DW-1:0];

  disp_bus_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
    .clk(clk), .rst_n(rst_n), .cs_n(bus_cs_n), .wr_n(bus_wr_n), .wr_pulse(wr_pulse)
  );

  assign wr_ok     = wr_pulse && !busy;
  assign clr_start = wr_ok && (sec == SEC_CTRL) && bus_din[7];
  assign glyph_we  = wr_ok && (sec == SEC_GROW);

  disp_init_seq #(.TICKS(INIT_TICKS)) i_seq (
    .clk(clk), .rst_n(rst_n), .tick(disp_tick), .start(clr_start),
    .busy(busy), .done(seq_done)
  );

  disp_glyph_ram #(.NG(NGLYPH), .NR(NROW), .NC(NCOL)) i_glyph (
    .clk(clk), .we(glyph_we), .widx(gptr_q), .wrow(bus_addr[2:0]),
    .wdata(bus_din[NCOL-1:0]),
    .ridx_a(gptr_q), .rrow_a(bus_addr[2:0]), .rdata_a(host_dots),
    .ridx_b(rf_glyph), .rrow_b(rf_row), .rdata_b(rf_glyph_dots)
  );

  // next-state for digit-indexed storage
  generate
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
      always_comb begin
        char_d[i]  = char_q[i];
        flash_d[i] = flash_q[i];
        if (busy) begin
          char_d[i]  = BLANK_CODE;
          flash_d[i] = 1'b0;
        end else if (wr_ok && loc == DW'(i)) begin
          if (sec == SEC_CHAR)  char_d[i]  = bus_din;
          if (sec == SEC_FLASH) flash_d[i] = bus_din[0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          char_q[i]  <= BLANK_CODE;
          flash_q[i] <= 1'b0;
        end else begin
          char_q[i]  <= char_d[i];
          flash_q[i] <= flash_d[i];
        end
      end
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_q;
    gptr_d = gptr_q;
    if (seq_done) ctrl_d[7] = 1'b0;
    if (wr_ok && sec == SEC_CTRL) ctrl_d = {bus_din[7:6], 1'b0, bus_din[4:0]};
    if (wr_ok && sec == SEC_GPTR) gptr_d = bus_din[GW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk) begin
    gptr_q <= gptr_d;
  end

  assign ctrl_word = {ctrl_q[7:6], st_pass, ctrl_q[4:0]};

  // host read path
  assign bus_oe = !bus_cs_n && !bus_rd_n;

  always_comb begin
    bus_dout = '0;
    if (bus_oe) begin
      case (sec)
        SEC_FLASH: bus_dout = {7'b0, flash_q[loc]};
        SEC_GPTR:  bus_dout = 8'(gptr_q);
        SEC_GROW:  bus_dout = 8'(host_dots);
        SEC_CTRL:  bus_dout = ctrl_word;
        default:   bus_dout = char_q[loc];
      endcase
    end
  end

  // refresh read path
  assign rf_char     = char_q[rf_digit];
  assign rf_is_glyph = rf_char[7];
  assign rf_code     = rf_char[7] ? {3'b0, rf_char[3:0]} : rf_char[6:0];
  assign rf_flash    = flash_q;
endmodule

// File: rtl/disp_host_regs_chk.sv
module disp_host_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_dout,
  input logic       bus_oe,
  input logic       busy,
  input logic [7:0] ctrl_word,
  input logic [7:0] rf_flash,
  input logic [3:0] gptr
);
  // R3: idle bus reads zero
  a_r3_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_dout == 8'h00);

  // R10: busy on the first cycle after reset release
  a_r10_busy_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> busy);

  // R9: clear bit returns to 0 when the sequence ends
  a_r9_bit7_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !ctrl_word[7]);

  // R9: flash vector is blank while busy
  a_r9_flash_blank: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> rf_flash == 8'h00);

  // R11: glyph pointer cannot move while busy
  a_r11_gptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(gptr));
endmodule

bind disp_host_regs disp_host_regs_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_dout(bus_dout), .bus_oe(bus_oe),
  .busy(busy), .ctrl_word(ctrl_word), .rf_flash(rf_flash), .gptr(gptr_q)
);

// File: tb/test_disp_host_regs.sv
module test_disp_host_regs;
  logic clk = 1'b0;
  logic rst_n, disp_tick, cs_n, wr_n, rd_n, fsel_n, st_pass;
  logic [4:0] addr;
  logic [7:0] din, dout, ctrl_word, rf_char, rf_flash;
  logic oe, busy, rf_is_glyph;
  logic [6:0] rf_code;
  logic [2:0] rf_digit, rf_row;
  logic [3:0] rf_glyph;
  logic [4:0] rf_dots;

  int checks = 0;
  int errors = 0;

  typedef struct { string tag; logic [7:0] exp; } item_t;
  item_t sb[$];
  event smp;

  always #10 clk = ~clk;

  disp_host_regs i_disp_host_regs (
    .clk(clk), .rst_n(rst_n), .disp_tick(disp_tick),
    .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n), .sel_flash_n(fsel_n),
    .bus_addr(addr), .bus_din(din), .bus_dout(dout), .bus_oe(oe),
    .st_pass(st_pass), .busy(busy), .ctrl_word(ctrl_word),
    .rf_digit(rf_digit), .rf_char(rf_char), .rf_is_glyph(rf_is_glyph),
    .rf_code(rf_code), .rf_flash(rf_flash), .rf_glyph(rf_glyph),
    .rf_row(rf_row), .rf_glyph_dots(rf_dots)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(smp) begin
    item_t it;
    it = sb.pop_front();
    chk({it.tag, " oe"}, {7'b0, oe}, 8'h01);
    chk(it.tag, dout, it.exp);
  end

  initial begin
    disp_tick = 1'b0;
    forever begin
      repeat (7) @(negedge clk);
      disp_tick = 1'b1;
      @(negedge clk);
      disp_tick = 1'b0;
    end
  end

  task automatic wr(input logic fs, input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    fsel_n = fs; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic fs, input logic [4:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.tag = tag; it.exp = e;
    sb.push_back(it);
    @(negedge clk);
    fsel_n = fs; addr = a;
    cs_n = 1'b0; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    -> smp;
    #1;
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 busy in reset", {7'b0, busy}, 8'h01);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 busy after release", {7'b0, busy}, 8'h01);
    repeat (40) @(negedge clk);
    chk("R10 busy ends", {7'b0, busy}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; fsel_n = 1'b1;
    addr = '0; din = '0; st_pass = 1'b0;
    rf_digit = '0; rf_glyph = '0; rf_row = '0;
    do_reset();

    // R10 reset state, R3 idle bus
    rd(1, 5'b11_000, 8'h20, "R10 char0 blank");
    rd(0, 5'b00_000, 8'h00, "R10 flash0 zero");
    rd(1, 5'b10_000, 8'h00, "R10 ctrl zero");
    @(negedge clk);
    cs_n = 1'b0; fsel_n = 1'b1; addr = 5'b11_000;
    @(negedge clk);
    chk("R3 oe low without read", {7'b0, oe}, 8'h00);
    chk("R3 dout zero idle", dout, 8'h00);
    cs_n = 1'b1;

    // R4 character store
    for (int i = 0; i < 8; i++) wr(1, {2'b11, 3'(i)}, 8'h41 + 8'(i) + (i == 6 ? 8'h80 : 8'h00));
    for (int i = 0; i < 8; i++)
      rd(1, {2'b11, 3'(i)}, 8'h41 + 8'(i) + (i == 6 ? 8'h80 : 8'h00), "R4 char readback");
    rf_digit = 3'd2; #1;
    chk("R4 rf ascii code", {1'b0, rf_code}, 8'h43);
    chk("R4 rf ascii sel", {7'b0, rf_is_glyph}, 8'h00);
    rf_digit = 3'd6; #1;
    chk("R4 rf glyph index", {1'b0, rf_code}, 8'h07);
    chk("R4 rf glyph sel", {7'b0, rf_is_glyph}, 8'h01);

    // R1 flash select overrides upper address, R7 flash bit
    wr(0, 5'b11_010, 8'hFF);
    rd(1, 5'b11_010, 8'h43, "R1 char untouched by flash");
    rd(0, 5'b01_010, 8'h01, "R7 flash set");
    wr(0, 5'b10_101, 8'h01);
    chk("R7 rf flash vector", rf_flash, 8'h24);
    wr(0, 5'b00_010, 8'hFE);
    rd(0, 5'b00_010, 8'h00, "R7 flash removed");

    // R5 glyph pointer, R6 glyph rows
    wr(1, 5'b00_000, 8'hA5);
    rd(1, 5'b00_111, 8'h05, "R5 pointer low bits");
    wr(1, 5'b01_010, 8'hF3);
    rd(1, 5'b01_010, 8'h13, "R6 row data bits");
    wr(1, 5'b01_111, 8'h1F);
    rd(1, 5'b01_111, 8'h00, "R6 row 7 absent");
    rf_glyph = 4'd5; rf_row = 3'd2; #1;
    chk("R6 rf dots", {3'b0, rf_dots}, 8'h13);

    // R8 control byte and read-only bit 5
    wr(1, 5'b10_000, 8'h3F);
    rd(1, 5'b10_000, 8'h1F, "R8 bit5 not writable");
    st_pass = 1'b1;
    wr(1, 5'b10_000, 8'h4A);
    rd(1, 5'b10_000, 8'h6A, "R8 full update with status");
    st_pass = 1'b0;

    // R2 write needs chip select; one write per select period
    @(negedge clk);
    fsel_n = 1'b1; addr = 5'b11_001; din = 8'h99;
    wr_n = 1'b0;
    repeat (5) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(1, 5'b11_001, 8'h42, "R2 no write without select");
    @(negedge clk);
    addr = 5'b11_001; din = 8'h55;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (2) @(negedge clk);
    din = 8'h66; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(1, 5'b11_001, 8'h55, "R2 single write per select");

    // R9 clear, R11 writes dropped while busy
    wr(1, 5'b00_000, 8'h03);
    wr(1, 5'b01_000, 8'h0E);
    wr(1, 5'b10_000, 8'h9C);
    chk("R9 busy on clear", {7'b0, busy}, 8'h01);
    wr(1, 5'b00_000, 8'h09);
    repeat (40) @(negedge clk);
    chk("R9 busy done", {7'b0, busy}, 8'h00);
    rd(1, 5'b10_000, 8'h1C, "R9 bit7 back to 0 others kept");
    rd(1, 5'b11_001, 8'h20, "R9 char blanked");
    rd(0, 5'b00_101, 8'h00, "R9 flash cleared");
    rd(1, 5'b00_000, 8'h03, "R11 pointer write dropped");
    rd(1, 5'b01_000, 8'h0E, "R9 glyph row kept");

    // R10 reset keeps glyph storage
    wr(1, 5'b11_100, 8'h58);
    wr(0, 5'b00_100, 8'h01);
    do_reset();
    rd(1, 5'b11_100, 8'h20, "R10 char blank after reset");
    rd(0, 5'b00_100, 8'h00, "R10 flash zero after reset");
    rd(1, 5'b10_000, 8'h00, "R10 ctrl zero after reset");
    rd(1, 5'b00_000, 8'h03, "R10 pointer kept");
    rd(1, 5'b01_000, 8'h0E, "R10 glyph row kept");

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule